// File: doc/BRIEF.md
# Reset Sequencer with Boot Configuration Capture

This block sits between the raw active-low reset pin of a small 16-bit processor and the core it holds in reset. Reset assertion takes effect at once, with no clock edge needed. Release passes through a two-stage synchronizer, so the core sees a clean edge. While the synchronized reset is active, the bus output enable stays low, so external pull resistors or an external driver set the level of every line of the multiplexed address/data bus. The sequencer copies that bus into a configuration register on every clock. Boards use this to report strap or jumper settings to software.

The configuration register freezes once the synchronized reset drops. A programmable settling delay then keeps the core in reset for `DELAY` more clocks. After that, the core and bus driver are released. The boot profile that the first fetch uses is held on dedicated outputs: the 20-bit start address 0xFFFF0, the upper-memory chip select enabled, and three wait states. A reset level goes to the external watchdog counter for as long as the synchronized reset is active.

Top module: `boot_reset_seq`

## Requirements
- R1: A low level on `rst_pin_n` forces `core_rst_n` and `bus_oe` low and `wdt_rst` high at once, with no clock edge needed, even for a pulse shorter than a clock period.
- R2: `wdt_rst` is high while the synchronized reset is active. It falls right after the second rising clock edge at which `rst_pin_n` is sampled high.
- R3: While `wdt_rst` is high, each rising clock edge loads the 16-bit value on `ad_in` into `cfg_word`.
- R4: `cfg_word` keeps the value that `ad_in` had at the last capturing edge, which is the second rising edge after the pin goes high. Later changes on `ad_in` have no effect on it until the next reset.
- R5: `core_rst_n` rises right after rising edge number 2+`DELAY` counted from the pin release. It stays low on every edge before that.
- R6: `bus_oe` is low during reset and during the settling delay. It goes high on the same edge as `core_rst_n`.
- R7: Whenever the core is out of reset, `boot_addr` is 0xFFFF0, `ucs_en` is 1 and `boot_waits` is 3.
- R8: Asserting the pin again during the settling delay restarts the whole sequence. Capture resumes and the full delay is counted again from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Raw active-low reset pin, asynchronous |
| ad_in | input | 16 | Address/data bus as sampled by the block |
| core_rst_n | output | 1 | Active-low reset to the processor core |
| bus_oe | output | 1 | Enables the core's bus drivers; low throughout reset |
| cfg_word | output | 16 | Captured configuration word |
| boot_addr | output | 20 | Physical address of the first fetch |
| ucs_en | output | 1 | Upper-memory chip select enable for boot |
| boot_waits | output | 2 | Wait states for boot accesses |
| wdt_rst | output | 1 | Reset level to the watchdog counter |

## Verification
A synchronizer stage that is off by one moves the fall of `wdt_rst` by a clock. It also changes which bus value is frozen in `cfg_word`. Both show up within two cycles of release, because the bench changes `ad_in` on every cycle around the release. A settling counter that stops at the wrong count or fails to clear moves the rise of `core_rst_n` and `bus_oe` away from edge 2+`DELAY`. A capture enable with the wrong sense either leaves `cfg_word` following the bus after release or leaves it unchanged during reset. Either fault appears at the first compare after the bus changes.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 20;
  localparam int unsigned WAIT_W   = 2;
  localparam logic [ADDR_W-1:0] BOOT_VECTOR = 20'hFFFF0;
  localparam logic [WAIT_W-1:0] BOOT_WAITS  = 2'd3;
endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // shift a one in from the bottom; async clear on pin assertion
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bsq_cfg_capture.sv
module bsq_cfg_capture #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] bus_d,
  output logic [WIDTH-1:0] word_q
);
  logic [WIDTH-1:0] word_d;

  // data register: loads only while the enable is active, no reset term
  always_comb begin
    word_d = cap_en ? bus_d : word_q;
  end

  always_ff @(posedge clk) begin
    word_q <= word_d;
  end
endmodule

// File: rtl/bsq_settle.sv
module bsq_settle #(
  parameter int unsigned DELAY = 8
) (
  input  logic clk,
  input  logic sync_n,
  output logic release_q
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          rel_d;

  always_comb begin
    cnt_en = (cnt_q != LAST);
    cnt_d  = cnt_en ? cnt_q + 1'b1 : cnt_q;
    rel_d  = (cnt_d == LAST);
  end

  always_ff @(posedge clk or negedge sync_n) begin
    if (!sync_n) begin
      cnt_q     <= '0;
      release_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      release_q <= rel_d;
    end
  end
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_seq_pkg::*;
#(
  parameter int unsigned DELAY       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic              core_rst_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] cfg_word,
  output logic [ADDR_W-1:0] boot_addr,
  output logic              ucs_en,
  output logic [WAIT_W-1:0] boot_waits,
  output logic              wdt_rst
);
  logic sync_n;
  logic released;

  bsq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_pin_n),
    .sync_n (sync_n)
  );

  bsq_cfg_capture #(.WIDTH(DATA_W)) u_cap (
    .clk    (clk),
    .cap_en (~sync_n),
    .bus_d  (ad_in),
    .word_q (cfg_word)
  );

  bsq_settle #(.DELAY(DELAY)) u_settle (
    .clk       (clk),
    .sync_n    (sync_n),
    .release_q (released)
  );

  assign core_rst_n = released;
  assign bus_oe     = released;
  assign wdt_rst    = ~sync_n;
  assign boot_addr  = BOOT_VECTOR;
  assign ucs_en     = 1'b1;
  assign boot_waits = BOOT_WAITS;
endmodule

// File: rtl/boot_reset_seq_chk.sv
module boot_reset_seq_chk
  import boot_seq_pkg::*;
#(
  parameter int unsigned DELAY = 8
) (
  input logic              clk,
  input logic              rst_pin_n,
  input logic [DATA_W-1:0] ad_in,
  input logic              core_rst_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] cfg_word,
  input logic [ADDR_W-1:0] boot_addr,
  input logic              ucs_en,
  input logic [WAIT_W-1:0] boot_waits,
  input logic              wdt_rst
);
  int unsigned since_wdt;

  always_ff @(posedge clk) begin
    if (wdt_rst)                  since_wdt <= 0;
    else if (since_wdt < 100000)  since_wdt <= since_wdt + 1;
  end

  // R3: capture of the bus while the watchdog reset is active
  assert_cfg_tracks_R3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $past(wdt_rst) |-> cfg_word == $past(ad_in));

  // R4: frozen after the synchronized release
  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (!wdt_rst && $past(!wdt_rst)) |-> $stable(cfg_word));

  // R5: release lands exactly DELAY edges after the watchdog reset falls
  assert_release_delay_R5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(core_rst_n) |-> since_wdt == DELAY);

  // R6: bus stays undriven whenever the core is held
  assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (wdt_rst || !core_rst_n) |-> !bus_oe);

  // R7: boot profile presented to the released core
  assert_boot_profile_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    core_rst_n |-> (boot_addr == BOOT_VECTOR && ucs_en && boot_waits == BOOT_WAITS));
endmodule

bind boot_reset_seq boot_reset_seq_chk #(.DELAY(DELAY)) u_chk (
  .clk        (clk),
  .rst_pin_n  (rst_pin_n),
  .ad_in      (ad_in),
  .core_rst_n (core_rst_n),
  .bus_oe     (bus_oe),
  .cfg_word   (cfg_word),
  .boot_addr  (boot_addr),
  .ucs_en     (ucs_en),
  .boot_waits (boot_waits),
  .wdt_rst    (wdt_rst)
);

// File: tb/boot_reset_seq_bench.sv
`timescale 1ns/1ps
module boot_reset_seq_bench;
  localparam int DELAY = 8;

  logic        clk;
  logic        rst_pin_n;
  logic [15:0] ad_in;
  logic        core_rst_n, bus_oe, ucs_en, wdt_rst;
  logic [15:0] cfg_word;
  logic [19:0] boot_addr;
  logic [1:0]  boot_waits;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit cmp_on = 0;

  boot_reset_seq #(.DELAY(DELAY)) u_boot_reset_seq (
    .clk(clk), .rst_pin_n(rst_pin_n), .ad_in(ad_in),
    .core_rst_n(core_rst_n), .bus_oe(bus_oe), .cfg_word(cfg_word),
    .boot_addr(boot_addr), .ucs_en(ucs_en), .boot_waits(boot_waits),
    .wdt_rst(wdt_rst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference: edges seen with the pin high since last assertion
  int          since = 0;
  logic [15:0] m_cfg;
  bit          m_cfg_ok = 0;

  always @(negedge rst_pin_n) since = 0;

  always @(posedge clk) begin
    if (since < 2) begin
      m_cfg    = ad_in;
      m_cfg_ok = 1;
    end
    if (!rst_pin_n)         since = 0;
    else if (since < 1000)  since = since + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, 5 ns after the rising edge
  always @(posedge clk) begin
    #5;
    if (cmp_on) begin
      chk("R2 wdt_rst", {31'd0, wdt_rst}, {31'd0, since < 2});
      chk("R5 core_rst_n", {31'd0, core_rst_n}, {31'd0, since >= 2 + DELAY});
      chk("R6 bus_oe", {31'd0, bus_oe}, {31'd0, since >= 2 + DELAY});
      if (m_cfg_ok) chk(since < 2 ? "R3 cfg_word" : "R4 cfg_word", {16'd0, cfg_word}, {16'd0, m_cfg});
      if (core_rst_n === 1'b1) begin
        chk("R7 boot_addr", {12'd0, boot_addr}, 32'h000FFFF0);
        chk("R7 ucs_en", {31'd0, ucs_en}, 32'd1);
        chk("R7 boot_waits", {30'd0, boot_waits}, 32'd3);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_pin_n = 1'b0;
    ad_in     = 16'hA5A5;
    #3;
    // R1: outputs held without any clock edge yet
    chk("R1 core_rst_n async", {31'd0, core_rst_n}, 32'd0);
    chk("R1 bus_oe async", {31'd0, bus_oe}, 32'd0);
    chk("R1 wdt_rst async", {31'd0, wdt_rst}, 32'd1);
    cmp_on = 1;
    cyc(3);
    ad_in = 16'h1234;           // R3: tracked during reset
    cyc(2);
    chk("R3 cfg follows bus", {16'd0, cfg_word}, 32'h1234);
    // release with the bus changing every cycle around it
    ad_in = 16'h0F0F; rst_pin_n = 1'b1;
    cyc(1); ad_in = 16'hBEEF;   // present at second edge -> kept
    cyc(1); ad_in = 16'hDEAD;
    cyc(1); ad_in = 16'h5555;
    cyc(DELAY + 3);
    chk("R4 cfg retained", {16'd0, cfg_word}, 32'hBEEF);
    chk("R5 core out of reset", {31'd0, core_rst_n}, 32'd1);
    ad_in = 16'h7777;
    cyc(4);
    chk("R4 cfg ignores bus", {16'd0, cfg_word}, 32'hBEEF);

    // R8: reassert inside the settling window
    rst_pin_n = 1'b0; ad_in = 16'h3C3C;
    cyc(3);
    rst_pin_n = 1'b1; ad_in = 16'h4242;
    cyc(5);                      // core still held
    chk("R8 held mid delay", {31'd0, core_rst_n}, 32'd0);
    rst_pin_n = 1'b0; ad_in = 16'h9999;
    cyc(2);
    chk("R8 capture resumed", {16'd0, cfg_word}, 32'h9999);
    rst_pin_n = 1'b1; ad_in = 16'h6161;
    cyc(DELAY + 1);
    chk("R8 full delay recounted", {31'd0, core_rst_n}, 32'd0);
    cyc(2);
    chk("R8 released", {31'd0, core_rst_n}, 32'd1);
    chk("R8 cfg from restart", {16'd0, cfg_word}, 32'h6161);

    // R1: narrow pulse inside the low clock phase
    cyc(3);
    ad_in = 16'h0BAD;
    #2 rst_pin_n = 1'b0;
    #1;
    chk("R1 narrow pulse core", {31'd0, core_rst_n}, 32'd0);
    chk("R1 narrow pulse oe", {31'd0, bus_oe}, 32'd0);
    chk("R1 narrow pulse wdt", {31'd0, wdt_rst}, 32'd1);
    #2 rst_pin_n = 1'b1;
    cyc(1); ad_in = 16'hC0DE;
    cyc(DELAY + 4);
    chk("R4 after narrow pulse", {16'd0, cfg_word}, 32'hC0DE);
    chk("R5 after narrow pulse", {31'd0, core_rst_n}, 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule